// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block watches twelve general-purpose pin inputs and one dedicated interrupt input, and turns activity on them into interrupt requests. The pins are split into two groups: pins 0 to 7 form group 0 and pins 8 to 11 form group 1. Each group has one mask bit per pin and a single sticky flag. Any toggle on an unmasked pin, rising or falling, sets that group's flag. The block samples the pin level whatever the pin's direction, so software can raise an interrupt by driving a pin that is set as an output.

The dedicated input has a two-bit sense select. It can request on a low level, on a falling edge or on a rising edge; one code is reserved and never requests. Edge detection runs on the clock. A low level and any unmasked pin difference also drive a combinational wake output, which needs no clock. A small register port gives access to the masks, the enables, the sense select and the flags. Writing 1 to a flag clears it.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, addresses 0 to 3 read 0x00 and all three request outputs are low.
- R2: Address 0 holds the group-0 mask, bit n for pin n. A toggle in either direction on a group-0 pin whose mask bit is 1 sets flag bit 0 (address 3). The flag is visible on the third rising clock edge after the pin changes: one edge for the input latch, one for the synchroniser, one for the flag.
- R3: Address 1 bits 3:0 hold the group-1 mask, bit n for pin 8+n. A toggle on an unmasked group-1 pin sets flag bit 1 with the same three-edge latency as R2.
- R4: A toggle on a pin whose mask bit is 0 leaves the flags unchanged.
- R5: A write to address 3 clears every flag bit written as 1 and leaves every flag bit written as 0 unchanged.
- R6: When a clear of a group flag and a detected toggle for that group fall in the same cycle, the flag stays set.
- R7: Address 2 holds enables: bit 0 for group 0, bit 1 for group 1, bit 2 for the dedicated input. Each request output is high only when its source is active and its enable bit is 1. A flag stays readable when its enable is 0.
- R8: Address 2 bits 4:3 select the sense of the dedicated input: 00 low level, 01 reserved, 10 falling edge, 11 rising edge. In mode 10 a falling edge sets flag bit 2 three edges later, and a rising edge does not. Mode 11 is the mirror of mode 10.
- R9: In mode 00 with the dedicated enable set, its request output follows the inverted synchronised input, two edges after the input changes. Flag bit 2 is never set in this mode.
- R10: In mode 01 neither edge of the dedicated input sets flag bit 2, and its request output stays low.
- R11: The wake output is high, without waiting for a clock edge, when an unmasked pin differs from its synchronised value. It is also high when the dedicated input is low with mode 00 and the dedicated enable set. Masked pins do not drive it.
- R12: Address 2 reads back bits 4:0 as written, with bits 7:5 read as 0. Address 1 reads back bits 3:0 as written, with bits 7:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Pin levels, bits 7:0 group 0, bits 11:8 group 1 |
| ext_i | input | 1 | Dedicated interrupt input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_grp0_o | output | 1 | Group-0 request |
| irq_grp1_o | output | 1 | Group-1 request |
| irq_ext_o | output | 1 | Dedicated-input request |
| wake_o | output | 1 | Clockless wake request |

## Verification
The hardest case to reach is the clear-versus-toggle collision of R6. The flag-clear write has to land in exactly the one cycle where a toggle is already inside the synchroniser but the flag has not yet been set again. The bench first sets the flag, then changes the pin, waits two rising edges and issues the clear write, so that the write strobe and the detected toggle share one cycle. The wake output is checked half a clock after the input changes, before any edge can affect it.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_MASK0 = 2'd0;
  localparam logic [1:0] ADDR_MASK1 = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_FLAG  = 2'd3;

  localparam int CTRL_EN_G0  = 0;
  localparam int CTRL_EN_G1  = 1;
  localparam int CTRL_EN_EXT = 2;
  localparam int CTRL_SENSE  = 3;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] toggle_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
    prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        chain_q[i] <= '0;
      end
      prev_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        chain_q[i] <= chain_d[i];
      end
      prev_q <= prev_d;
    end
  end

  assign sync_o   = chain_q[STAGES-1];
  assign toggle_o = chain_q[STAGES-1] ^ prev_q;

  // R4: a synchronised level that has held for a cycle reports no toggle
  assert_quiet_no_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sync_o) |-> (toggle_o == '0));
endmodule

// File: rtl/pin_irq_group.sv
module pin_irq_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] toggle_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic         en_i,
  output logic         flag_o,
  output logic         irq_o
);
  logic hit;
  logic flag_q;
  logic flag_d;

  always_comb begin
    hit    = |(toggle_i & mask_i);
    flag_d = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R2 and R3: an unmasked toggle sets the flag on the next edge
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !flag_o);
  assert_clear_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit) |=> flag_o);
  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((toggle_i & mask_i) == '0) && !flag_o) |=> !flag_o);
endmodule

// File: rtl/pin_irq_ext.sv
module pin_irq_ext
  import pin_irq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_i,
  input  sense_e sense_i,
  input  logic   en_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   irq_o,
  output logic   level_wake_o
);
  logic ext_sync;
  logic ext_tog;
  logic fall_det;
  logic rise_det;
  logic det;
  logic flag_q;
  logic flag_d;

  pin_irq_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (ext_i),
    .sync_o   (ext_sync),
    .toggle_o (ext_tog)
  );

  always_comb begin
    fall_det = ext_tog & ~ext_sync;
    rise_det = ext_tog & ext_sync;
    unique case (sense_i)
      SENSE_FALL: det = fall_det;
      SENSE_RISE: det = rise_det;
      default:    det = 1'b0;
    endcase
    flag_d = det | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o       = flag_q;
  assign irq_o        = en_i & ((sense_i == SENSE_LOW) ? ~ext_sync : flag_q);
  assign level_wake_o = en_i & (sense_i == SENSE_LOW) & ~ext_i;

  assert_fall_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_FALL && ext_tog && !ext_sync) |=> flag_o);
  assert_rise_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_RISE && ext_tog && ext_sync) |=> flag_o);
  assert_level_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_LOW && !flag_o) |=> !flag_o);
  assert_rsvd_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_RSVD && !flag_o) |=> !flag_o);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int N_GRP0      = 8,
  parameter int N_GRP1      = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_GRP0+N_GRP1-1:0] pin_i,
  input  logic                     ext_i,
  input  logic                     wr_en,
  input  logic [1:0]               addr,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data,
  output logic                     irq_grp0_o,
  output logic                     irq_grp1_o,
  output logic                     irq_ext_o,
  output logic                     wake_o
);
  localparam int N_PINS   = N_GRP0 + N_GRP1;
  localparam int N_FLAGS  = 3;
  localparam int CTRL_W   = CTRL_SENSE + 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  // configuration registers
  logic [N_GRP0-1:0]  mask0_q, mask0_d;
  logic [N_GRP1-1:0]  mask1_q, mask1_d;
  logic [2:0]         en_q, en_d;
  sense_e             sense_q, sense_d;
  logic               wr_mask0, wr_mask1, wr_ctrl, wr_flag;
  logic [N_FLAGS-1:0] clr_flags;

  always_comb begin
    wr_mask0  = wr_en && (addr == ADDR_MASK0);
    wr_mask1  = wr_en && (addr == ADDR_MASK1);
    wr_ctrl   = wr_en && (addr == ADDR_CTRL);
    wr_flag   = wr_en && (addr == ADDR_FLAG);
    mask0_d   = wr_mask0 ? wr_data[N_GRP0-1:0] : mask0_q;
    mask1_d   = wr_mask1 ? wr_data[N_GRP1-1:0] : mask1_q;
    en_d      = wr_ctrl ? wr_data[CTRL_EN_EXT:CTRL_EN_G0] : en_q;
    sense_d   = wr_ctrl ? sense_e'(wr_data[CTRL_SENSE+1:CTRL_SENSE]) : sense_q;
    clr_flags = wr_flag ? wr_data[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask0_q <= '0;
      mask1_q <= '0;
      en_q    <= '0;
      sense_q <= SENSE_LOW;
    end else begin
      mask0_q <= mask0_d;
      mask1_q <= mask1_d;
      en_q    <= en_d;
      sense_q <= sense_d;
    end
  end

  // pin path: input latch + synchroniser + toggle compare
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] pin_tog;

  pin_irq_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .d_i      (pin_i),
    .sync_o   (pin_sync),
    .toggle_o (pin_tog)
  );

  logic flag_g0, flag_g1, flag_ext;

  pin_irq_group #(.W(N_GRP0)) u_grp0 (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .toggle_i (pin_tog[N_GRP0-1:0]),
    .mask_i   (mask0_q),
    .clr_i    (clr_flags[0]),
    .en_i     (en_q[CTRL_EN_G0]),
    .flag_o   (flag_g0),
    .irq_o    (irq_grp0_o)
  );

  pin_irq_group #(.W(N_GRP1)) u_grp1 (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .toggle_i (pin_tog[N_PINS-1:N_GRP0]),
    .mask_i   (mask1_q),
    .clr_i    (clr_flags[1]),
    .en_i     (en_q[CTRL_EN_G1]),
    .flag_o   (flag_g1),
    .irq_o    (irq_grp1_o)
  );

  logic ext_level_wake;

  pin_irq_ext #(.STAGES(SYNC_STAGES)) u_ext (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .ext_i        (ext_i),
    .sense_i      (sense_q),
    .en_i         (en_q[CTRL_EN_EXT]),
    .clr_i        (clr_flags[2]),
    .flag_o       (flag_ext),
    .irq_o        (irq_ext_o),
    .level_wake_o (ext_level_wake)
  );

  // clockless wake: raw pin level against synchronised copy
  logic [N_PINS-1:0] pin_diff;
  always_comb begin
    pin_diff = (pin_i ^ pin_sync) & {mask1_q, mask0_q};
    wake_o   = (|pin_diff) | ext_level_wake;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (addr)
      ADDR_MASK0: rd_data[N_GRP0-1:0]  = mask0_q;
      ADDR_MASK1: rd_data[N_GRP1-1:0]  = mask1_q;
      ADDR_CTRL:  rd_data[CTRL_W-1:0]  = {sense_q, en_q};
      default:    rd_data[N_FLAGS-1:0] = {flag_ext, flag_g1, flag_g0};
    endcase
  end

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (irq_grp0_o |-> en_q[CTRL_EN_G0]) and (irq_grp1_o |-> en_q[CTRL_EN_G1])
    and (irq_ext_o |-> en_q[CTRL_EN_EXT]));
  assert_wake_level_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en_q[CTRL_EN_EXT] && sense_q == SENSE_LOW && !ext_i) |-> wake_o);
endmodule

// File: tb/sim_pin_irq_ctrl.sv
module sim_pin_irq_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic [11:0] pins;
  logic        ext_in;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        irq0, irq1, irqx, wake;

  pin_irq_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pins),
    .ext_i      (ext_in),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq_grp0_o (irq0),
    .irq_grp1_o (irq1),
    .irq_ext_o  (irqx),
    .wake_o     (wake)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0:       return {5'b0, irqx, irq1, irq0};
      1:       return rd_data;
      default: return {7'b0, wake};
    endcase
  endfunction

  task automatic compare(int sel, logic [7:0] exp, string req);
    logic [7:0] act;
    act = observe(sel);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel=%0d actual=%h expected=%h", req, sel, act, exp);
    end
  endtask

  // monitor: pop due items at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      compare(it.sel, it.exp, it.req);
    end
  end

  task automatic expect_in(int n, int sel, logic [7:0] exp, string req);
    q.push_back('{cyc + n, sel, exp, req});
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(logic [1:0] a, logic [7:0] exp, string req);
    addr = a;
    expect_in(1, 1, exp, req);
    tick(1);
  endtask

  task automatic irq_check(logic [2:0] exp, string req);
    expect_in(1, 0, {5'b0, exp}, req);
    tick(1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; ext_in = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    rd_check(2'd0, 8'h00, "R1");
    rd_check(2'd1, 8'h00, "R1");
    rd_check(2'd2, 8'h00, "R1");
    rd_check(2'd3, 8'h00, "R1");
    irq_check(3'b000, "R1");

    // R12 readback
    wr(2'd0, 8'hA5); rd_check(2'd0, 8'hA5, "R12");
    wr(2'd1, 8'hFF); rd_check(2'd1, 8'h0F, "R12");
    wr(2'd2, 8'hFF); rd_check(2'd2, 8'h1F, "R12");

    // setup: pin0 and pin10 unmasked, all enables, falling edge
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h17);

    // R2 rising toggle
    pins[0] = 1'b1; tick(3);
    rd_check(2'd3, 8'h01, "R2");
    irq_check(3'b001, "R7");

    // R5 clear semantics
    wr(2'd3, 8'h00); rd_check(2'd3, 8'h01, "R5");
    wr(2'd3, 8'h01); rd_check(2'd3, 8'h00, "R5");

    // R2 falling toggle
    pins[0] = 1'b0; tick(3);
    rd_check(2'd3, 8'h01, "R2");
    wr(2'd3, 8'h01);

    // R4 masked pins
    pins[1] = 1'b1; tick(4);
    rd_check(2'd3, 8'h00, "R4");
    pins[8] = 1'b1; tick(4);
    rd_check(2'd3, 8'h00, "R4");

    // R3 group 1
    pins[10] = 1'b1; tick(3);
    rd_check(2'd3, 8'h02, "R3");
    irq_check(3'b010, "R7");
    wr(2'd3, 8'h02);

    // R7 enable gating
    pins[0] = 1'b1; tick(3);
    wr(2'd2, 8'h16);
    irq_check(3'b000, "R7");
    rd_check(2'd3, 8'h01, "R7");
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h17);

    // R6 clear colliding with a detected toggle
    pins[0] = 1'b0; tick(3);
    pins[0] = 1'b1; tick(2);
    wr(2'd3, 8'h01);
    rd_check(2'd3, 8'h01, "R6");
    wr(2'd3, 8'h01);
    rd_check(2'd3, 8'h00, "R5");

    // R11 wake from pins
    pins[0] = 1'b0;
    expect_in(1, 2, 8'h01, "R11");
    expect_in(3, 2, 8'h00, "R11");
    tick(3);
    wr(2'd3, 8'h01);
    pins[2] = 1'b1;
    expect_in(1, 2, 8'h00, "R11");
    tick(3);

    // R8 falling mode
    ext_in = 1'b0; tick(3);
    rd_check(2'd3, 8'h04, "R8");
    irq_check(3'b100, "R8");
    wr(2'd3, 8'h04);
    ext_in = 1'b1; tick(4);
    rd_check(2'd3, 8'h00, "R8");
    // R8 rising mode
    wr(2'd2, 8'h1F);
    ext_in = 1'b0; tick(4);
    rd_check(2'd3, 8'h00, "R8");
    ext_in = 1'b1; tick(3);
    rd_check(2'd3, 8'h04, "R8");
    wr(2'd3, 8'h04);

    // R10 reserved mode
    wr(2'd2, 8'h0F);
    ext_in = 1'b0; tick(4);
    ext_in = 1'b1; tick(4);
    rd_check(2'd3, 8'h00, "R10");
    irq_check(3'b000, "R10");

    // R9 low level
    wr(2'd2, 8'h07);
    irq_check(3'b000, "R9");
    ext_in = 1'b0;
    #0.5;
    compare(2, 8'h01, "R11");
    expect_in(2, 0, 8'h04, "R9");
    tick(2);
    tick(2);
    rd_check(2'd3, 8'h00, "R9");
    ext_in = 1'b1;
    expect_in(2, 0, 8'h00, "R9");
    tick(2);

    // R11 level wake needs the enable
    wr(2'd2, 8'h03);
    ext_in = 1'b0;
    #0.5;
    compare(2, 8'h00, "R11");
    tick(3);
    ext_in = 1'b1;
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule